// File: doc/BRIEF.md
# Pending FPU exception arbitration controller

This controller sits at the point where a processor starts a target instruction (a floating-point, packed-SIMD or WAIT instruction) and settles what happens when an unmasked floating-point exception raised by an earlier floating-point instruction is still outstanding. It produces exactly one of three results:

- the instruction goes ahead;
- a fault on exception vector 16 is requested;
- control is handed to interrupt servicing.

Which result it picks depends on four things:

- whether the target instruction is error-sensitive;
- the numeric-error mode bit;
- an active-low ignore-error pin;
- four external interrupt sources.

When the mode bit is clear and the ignore pin is not asserted, the controller stalls the instruction. Only the ignore pin or an interrupt source can release that stall.

The block also drives an active-low error pin. That pin goes low at the boundary of the first target instruction that meets the pending exception. It stays low until the exception is cleared. All pin inputs are asynchronous and pass through two-flop synchronizers. Reset is synchronous and active high.

Top module: `fpx_arbiter`

## Requirements
- R1: In reset and on the first cycle after it, the error pin is high, the stall flag is low, no outcome pulses, and no exception is pending.
- R2: A target strobe with no exception pending gives a one-cycle proceed pulse on the cycle after the strobe.
- R3: With an exception pending and the target marked error-insensitive, the result is proceed, whatever the mode bit and the ignore pin.
- R4: With an exception pending, the target error-sensitive and the mode bit at 1, the cycle after the strobe carries a one-cycle vector request with vector number 16 (0x10). No stall occurs.
- R5: With an exception pending, the target error-sensitive, the mode bit at 0 and the synchronized ignore pin low, the result is proceed.
- R6: With an exception pending, the target error-sensitive, the mode bit at 0 and the synchronized ignore pin high, the stall flag rises on the cycle after the strobe. While the flag stays high, no outcome pulses and further target strobes have no effect.
- R7: While stalled, driving the ignore pin low releases the stall with a proceed pulse. Through the two synchronizer flops this happens on the third rising edge after the pin changes, so the stall flag is still high after the second edge.
- R8: While stalled, an asserted interrupt source releases the stall with a service pulse and a 2-bit source code: 3 for INIT, 2 for SMI, 1 for NMI, 0 for INTR. Priority runs INIT, SMI, NMI, INTR, and the ignore pin is checked before all of them.
- R9: The error pin goes low on the cycle after a target strobe meets a pending exception, whatever the mode bit, the ignore pin or the sensitivity. It stays low until a clear pulse arrives. The clear pulse drives the pin high and drops the pending flag.
- R10: At most one of proceed, vector request and service is asserted in any cycle. Each target strobe gives at most one outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_set_i | input | 1 | Pulse: an unmasked exception was raised |
| fault_clr_i | input | 1 | Pulse: clears the pending exception and the error pin |
| tgt_vld_i | input | 1 | Target instruction starts this cycle |
| tgt_sens_i | input | 1 | Target instruction is error-sensitive |
| err_mode_i | input | 1 | Numeric-error mode: 1 selects the internal vector fault |
| ign_n_i | input | 1 | Ignore-error pin, active low, asynchronous |
| irq_i | input | 1 | INTR source, asynchronous |
| nmask_i | input | 1 | NMI source, asynchronous |
| smgmt_i | input | 1 | SMI source, asynchronous |
| cpu_init_i | input | 1 | INIT source, asynchronous |
| go_o | output | 1 | Proceed pulse |
| vec_req_o | output | 1 | Exception vector request pulse |
| vec_num_o | output | 8 | Vector number, 16 while a request is shown |
| svc_o | output | 1 | Interrupt-service handoff pulse |
| svc_src_o | output | 2 | Source code of the handoff |
| stall_o | output | 1 | Target instruction is held waiting |
| err_n_o | output | 1 | Error pin, active low |

## Verification
The decision is exercised with several input patterns, each telling a different pair of outcomes apart:

- Strobes with no exception pending against strobes with one pending show whether the pending flag is consulted.
- Insensitive strobes with the mode bit both low and high show that sensitivity overrides the mode bit.
- Sensitive strobes with the ignore pin low and high tell the proceed path from the stall.

Stalls are released by the ignore pin alone, by all four interrupt sources at once, by smaller subsets, and by the ignore pin together with INIT. This separates the priority order and the ignore-first rule. A clear pulse followed by a sensitive strobe in vector mode shows whether the pending flag really drops, because a stale flag would produce a vector request instead of proceed.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int unsigned SRC_N = 4;
  localparam int unsigned SRC_W = $clog2(SRC_N);

  typedef enum logic [1:0] {
    ACT_GO    = 2'd0,
    ACT_VEC   = 2'd1,
    ACT_STALL = 2'd2
  } act_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;

  // Outcome at a target boundary, given pending state and the qualifiers.
  function automatic act_e fpx_decide(logic pend, logic sens, logic mode, logic ign_on);
    if (!pend || !sens) return ACT_GO;
    if (mode)           return ACT_VEC;
    if (ign_on)         return ACT_GO;
    return ACT_STALL;
  endfunction

endpackage

// File: rtl/fpx_sync.sv
module fpx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fpx_wake_pri.sv
module fpx_wake_pri #(
  parameter int unsigned N  = 4,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o,
  output logic          any_o
);
  // Highest index wins.
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && grant_o == '0) grant_o[i] = 1'b1;
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) code_o = CW'(i);
    end
  end

  assign any_o = |req_i;

  // R8: a single winner, and only when something requests
  always_comb begin
    assert_grant_onehot_R8: assert ($onehot0(grant_o) && ((grant_o != '0) == any_o));
  end
endmodule

// File: rtl/fpx_pend_track.sv
module fpx_pend_track (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic boundary_i,
  output logic pend_o,
  output logic err_n_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                        err_n_o <= 1'b1;
    else if (clr_i)                 err_n_o <= 1'b1;
    else if (boundary_i && pend_o)  err_n_o <= 1'b0;
  end

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!err_n_o && !clr_i) |=> !err_n_o);

  assert_err_needs_pend_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(err_n_o) |-> $past(pend_o && boundary_i));
endmodule

// File: rtl/fpx_arbiter.sv
module fpx_arbiter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned FAULT_VEC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_set_i,
  input  logic             fault_clr_i,
  input  logic             tgt_vld_i,
  input  logic             tgt_sens_i,
  input  logic             err_mode_i,
  input  logic             ign_n_i,
  input  logic             irq_i,
  input  logic             nmask_i,
  input  logic             smgmt_i,
  input  logic             cpu_init_i,
  output logic             go_o,
  output logic             vec_req_o,
  output logic [VEC_W-1:0] vec_num_o,
  output logic             svc_o,
  output logic [1:0]       svc_src_o,
  output logic             stall_o,
  output logic             err_n_o
);
  import fpx_pkg::*;

  localparam int unsigned   PIN_W   = SRC_N + 1;
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_VEC);

  // Pins: bit 0 ignore (active low), bits 1..4 INTR, NMI, SMI, INIT.
  logic [PIN_W-1:0] pins_raw, pins_s;
  assign pins_raw = {cpu_init_i, smgmt_i, nmask_i, irq_i, ign_n_i};

  fpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_W'(1))) u_sync (
    .clk (clk), .rst (rst), .d_i (pins_raw), .q_o (pins_s)
  );

  logic             ign_on;
  logic [SRC_N-1:0] wake_req, wake_grant;
  logic [SRC_W-1:0] wake_code;
  logic             wake_any;
  assign ign_on   = ~pins_s[0];
  assign wake_req = pins_s[PIN_W-1:1];

  fpx_wake_pri #(.N(SRC_N)) u_pri (
    .req_i (wake_req), .grant_o (wake_grant), .code_o (wake_code), .any_o (wake_any)
  );

  st_e  st_q;
  logic boundary, pend;
  act_e act;
  assign boundary = tgt_vld_i && (st_q == ST_IDLE);
  assign act      = fpx_decide(pend, tgt_sens_i, err_mode_i, ign_on);

  fpx_pend_track u_pend (
    .clk (clk), .rst (rst), .set_i (fault_set_i), .clr_i (fault_clr_i),
    .boundary_i (boundary), .pend_o (pend), .err_n_o (err_n_o)
  );

  logic             go_q, vec_q, svc_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      go_q <= 1'b0; vec_q <= 1'b0; svc_q <= 1'b0; src_q <= '0;
    end else begin
      go_q <= 1'b0; vec_q <= 1'b0; svc_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (tgt_vld_i) begin
          case (act)
            ACT_GO:    go_q  <= 1'b1;
            ACT_VEC:   vec_q <= 1'b1;
            default:   st_q  <= ST_WAIT;
          endcase
        end
        ST_WAIT: begin
          if (ign_on) begin
            go_q <= 1'b1;
            st_q <= ST_IDLE;
          end else if (wake_any) begin
            svc_q <= 1'b1;
            src_q <= wake_code;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o      = go_q;
  assign vec_req_o = vec_q;
  assign vec_num_o = vec_q ? VEC_VAL : '0;
  assign svc_o     = svc_q;
  assign svc_src_o = 2'(src_q);
  assign stall_o   = (st_q == ST_WAIT);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_o, vec_req_o, svc_o}));

  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !(go_o || vec_req_o || svc_o));

  assert_wait_exit_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> (go_o || svc_o));

  assert_vec_cause_R4: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> $past(err_mode_i && tgt_vld_i && tgt_sens_i && !stall_o));

  assert_svc_from_wait_R8: assert property (@(posedge clk) disable iff (rst)
    svc_o |-> $past(stall_o));
endmodule

// File: tb/test_fpx_arbiter.sv
module test_fpx_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault_set_i = 0, fault_clr_i = 0, tgt_vld_i = 0, tgt_sens_i = 0, err_mode_i = 0;
  logic ign_n_i = 1, irq_i = 0, nmask_i = 0, smgmt_i = 0, cpu_init_i = 0;
  logic go_o, vec_req_o, svc_o, stall_o, err_n_o;
  logic [7:0] vec_num_o;
  logic [1:0] svc_src_o;

  always #10 clk = ~clk; // 50 MHz

  fpx_arbiter i_fpx_arbiter (
    .clk(clk), .rst(rst), .fault_set_i(fault_set_i), .fault_clr_i(fault_clr_i),
    .tgt_vld_i(tgt_vld_i), .tgt_sens_i(tgt_sens_i), .err_mode_i(err_mode_i),
    .ign_n_i(ign_n_i), .irq_i(irq_i), .nmask_i(nmask_i), .smgmt_i(smgmt_i),
    .cpu_init_i(cpu_init_i), .go_o(go_o), .vec_req_o(vec_req_o), .vec_num_o(vec_num_o),
    .svc_o(svc_o), .svc_src_o(svc_src_o), .stall_o(stall_o), .err_n_o(err_n_o)
  );

  int total = 0, bad = 0;
  bit finished = 0, mon_on = 0;
  // Expected item: req*100 + kind*10 + code; kind 1 proceed, 2 vector, 3 service
  int exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_kind(bit pend, bit sens, bit mode, bit ign_low);
    if (!pend || !sens) return 1;
    if (mode) return 2;
    if (ign_low) return 1;
    return 0; // stall
  endfunction

  // Monitor: pops one expected item per observed outcome
  always @(negedge clk) begin
    if (mon_on && !rst && (go_o || vec_req_o || svc_o)) begin
      int got;
      got = go_o ? 10 : vec_req_o ? 20 : (30 + int'(svc_src_o));
      chk($countones({go_o, vec_req_o, svc_o}) == 1, "R10", got, 0);
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected outcome", got, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(got == e % 100, $sformatf("R%0d", e / 100), got, e % 100);
        if (vec_req_o) chk(vec_num_o == 8'd16, "R4 vector", vec_num_o, 16);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic target(input bit pend, input bit sens, input bit mode, input bit ign_low, input int req);
    int k;
    k = model_kind(pend, sens, mode, ign_low);
    tgt_vld_i = 1; tgt_sens_i = sens; err_mode_i = mode;
    if (k != 0) exp_q.push_back(req * 100 + k * 10);
    @(negedge clk);
    tgt_vld_i = 0;
  endtask

  task automatic set_ign(input bit low);
    ign_n_i = ~low;
    cyc(3);
  endtask

  // Enter the stall: pending, sensitive, mode 0, ignore high
  task automatic enter_stall;
    target(1, 1, 0, 0, 6);
    chk(stall_o == 1, "R6 stall rises", stall_o, 1);
  endtask

  task automatic wake(input bit [3:0] src, input int exp_item);
    {cpu_init_i, smgmt_i, nmask_i, irq_i} = src;
    exp_q.push_back(exp_item);
    cyc(2);
    chk(stall_o == 1, "R7 stall after two edges", stall_o, 1);
    cyc(1);
    chk(stall_o == 0, "R8 stall released", stall_o, 0);
    {cpu_init_i, smgmt_i, nmask_i, irq_i} = 4'b0;
    ign_n_i = 1;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    chk(err_n_o == 1 && stall_o == 0 && !go_o && !vec_req_o && !svc_o, "R1 in reset",
        {err_n_o, stall_o, go_o, vec_req_o, svc_o}, 5'b10000);
    rst = 0;
    mon_on = 1;
    cyc(1);
    chk(err_n_o == 1 && stall_o == 0, "R1 after reset", {err_n_o, stall_o}, 2'b10);

    target(0, 1, 0, 0, 2);                       // R2 no pending
    chk(err_n_o == 1, "R9 no pending no error", err_n_o, 1);

    fault_set_i = 1; cyc(1); fault_set_i = 0;
    target(1, 0, 0, 0, 3);                       // R3 insensitive, mode 0
    chk(err_n_o == 0, "R9 error low at boundary", err_n_o, 0);
    target(1, 0, 1, 0, 3);                       // R3 insensitive, mode 1
    target(1, 1, 1, 0, 4);                       // R4 vector 16
    chk(stall_o == 0, "R4 no stall", stall_o, 0);

    set_ign(1);
    target(1, 1, 0, 1, 5);                       // R5 ignore low
    set_ign(0);

    enter_stall();
    cyc(4);
    chk(stall_o == 1, "R6 stall held", stall_o, 1);
    tgt_vld_i = 1; tgt_sens_i = 0; cyc(1); tgt_vld_i = 0;   // R6 ignored strobe
    cyc(1);
    chk(stall_o == 1, "R6 strobe ignored while stalled", stall_o, 1);
    ign_n_i = 0;
    wake(4'b0000, 7 * 100 + 10);                 // R7 ignore release

    enter_stall(); wake(4'b1111, 8 * 100 + 33);  // R8 INIT wins
    enter_stall(); wake(4'b0101, 8 * 100 + 32);  // R8 SMI over INTR
    enter_stall(); wake(4'b0011, 8 * 100 + 31);  // R8 NMI over INTR
    enter_stall(); wake(4'b0001, 8 * 100 + 30);  // R8 INTR alone
    enter_stall(); ign_n_i = 0; wake(4'b1000, 8 * 100 + 10); // R8 ignore before INIT

    chk(err_n_o == 0, "R9 error held", err_n_o, 0);
    fault_clr_i = 1; cyc(1); fault_clr_i = 0;
    chk(err_n_o == 1, "R9 clear raises pin", err_n_o, 1);
    target(0, 1, 1, 0, 9);                       // R9 pending dropped
    chk(err_n_o == 1, "R9 pin stays high", err_n_o, 1);

    cyc(3);
    chk(exp_q.size() == 0, "R10 all outcomes seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule